// File: doc/BRIEF.md
# Bidirectional Ring Router Output Stage with Dateline Channel Choice

This block is the forwarding stage of one node on a bidirectional ring network-on-chip. Flits enter through a single input register with a valid/ready handshake. Each packet's head flit picks a path, and the flits behind it follow that path without being routed again. A packet addressed to this node leaves through the local eject port. Every other packet goes onto the clockwise or counter-clockwise link, whichever reaches the destination in fewer hops.

Traffic is split into two virtual networks, one for requests and one for replies, so that the two classes cannot block each other. Inside each virtual network there are two virtual channels, chosen by a modulo-diameter dateline rule that breaks cyclic waiting around the ring. Each ring link owns four small queues, one for each pairing of virtual network and channel. Every cycle an arbiter alternates service between the two virtual networks. Inside a virtual network, the channel that wins the link keeps it until its packet is complete. The next hop grants permission separately for each pairing of virtual network and channel.

Top module: `ring_dateline_router`

## Requirements
- R1: Once reset is released, the input is ready and none of the local, clockwise or counter-clockwise outputs is valid.
- R2: A packet whose destination equals NODE_ID leaves only on the local port, in order, and only while `loc_ready` is high.
- R3: The link is chosen from the clockwise hop count h = (dest − NODE_ID) mod N. It is clockwise when 0 < h ≤ N/2, so a tie at exactly half the ring goes clockwise. Otherwise the packet takes the counter-clockwise link.
- R4: Let s = NODE_ID mod D and t = dest mod D. The virtual channel is 0 when s > t and 1 otherwise. It is reported on `*_vc`.
- R5: Flits after the head take the head's link and channel, and they leave in the order they arrived with head, tail, destination and data unchanged.
- R6: A ring link sends at most one flit per cycle. A flit for virtual network v and channel c leaves only while bit {v,c} (that is, 2·v + c) of that link's `*_rdy` input is high.
- R7: Each queue holds QDEPTH flits. With QDEPTH = 3 and the link's ready bits held low, an incoming five-flit packet has four flits accepted: three fill the queue and one waits in the input register. `in_ready` then stays low.
- R8: When both virtual networks have flits that may leave on a link, consecutive flits on that link alternate between the virtual networks.
- R9: Within one virtual network on a link, a packet that has started keeps the link until its tail flit. When no packet holds the link, channel 0 wins over channel 1.
- R10: Every accepted flit leaves the block exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming flit present |
| in_ready | output | 1 | Input register can take a flit |
| in_head | input | 1 | Incoming flit starts a packet |
| in_tail | input | 1 | Incoming flit ends a packet |
| in_vnet | input | 1 | Virtual network: 0 request, 1 reply |
| in_dest | input | $clog2(N) | Destination node |
| in_data | input | DW | Payload |
| loc_valid | output | 1 | Ejected flit present |
| loc_ready | input | 1 | Local sink accepts |
| loc_head | output | 1 | Ejected flit head marker |
| loc_tail | output | 1 | Ejected flit tail marker |
| loc_vnet | output | 1 | Ejected flit virtual network |
| loc_dest | output | $clog2(N) | Ejected flit destination |
| loc_data | output | DW | Ejected flit payload |
| cw_valid | output | 1 | Clockwise link sends a flit this cycle |
| cw_head | output | 1 | Clockwise flit head marker |
| cw_tail | output | 1 | Clockwise flit tail marker |
| cw_vnet | output | 1 | Clockwise flit virtual network |
| cw_vc | output | 1 | Clockwise flit virtual channel |
| cw_dest | output | $clog2(N) | Clockwise flit destination |
| cw_data | output | DW | Clockwise flit payload |
| cw_rdy | input | 4 | Next clockwise hop has room, bit 2·vnet+vc |
| ccw_valid | output | 1 | Counter-clockwise link sends a flit this cycle |
| ccw_head | output | 1 | Counter-clockwise flit head marker |
| ccw_tail | output | 1 | Counter-clockwise flit tail marker |
| ccw_vnet | output | 1 | Counter-clockwise flit virtual network |
| ccw_vc | output | 1 | Counter-clockwise flit virtual channel |
| ccw_dest | output | $clog2(N) | Counter-clockwise flit destination |
| ccw_data | output | DW | Counter-clockwise flit payload |
| ccw_rdy | input | 4 | Next counter-clockwise hop has room, bit 2·vnet+vc |

## Verification
The assertions take for granted that the input carries well-formed packets: every packet opens with a head flit, closes with a tail flit, and keeps one virtual network throughout. They also assume the fields stay steady while `in_valid` waits for `in_ready`. The stimulus builds each packet from a head, optional body flits and a tail of one length. It holds every field until the handshake completes, and it chooses destinations only from the N existing nodes. The ready masks on both ring links and the local ready are drawn at random each cycle. This exercises stalls in the middle of a packet without ever breaking those assumptions.

// File: rtl/ring_rtr_pkg.sv
// Shared constants and the path-target type of the ring router.
// Assumes exactly two virtual networks and two virtual channels per link.
package ring_rtr_pkg;
    localparam int NUM_VN  = 2;
    localparam int NUM_VC  = 2;
    localparam int NUM_Q   = NUM_VN * NUM_VC;
    localparam int NUM_DIR = 2;
    localparam int QSEL_W  = $clog2(NUM_Q);

    typedef enum logic [1:0] {
        TGT_LOCAL = 2'd0,
        TGT_CW    = 2'd1,
        TGT_CCW   = 2'd2
    } tgt_e;
endpackage

// File: rtl/ring_route_calc.sv
// Path computation for a head flit: local eject, shorter ring direction
// (ties go clockwise) and dateline virtual channel from the modulo-D compare.
// Assumes dest < N. Purely combinational.
module ring_route_calc
    import ring_rtr_pkg::*;
#(
    parameter int N       = 8,
    parameter int D       = 4,
    parameter int NODE_ID = 2,
    parameter int IDW     = $clog2(N)
) (
    input  logic [IDW-1:0] dest,
    output tgt_e           tgt,
    output logic           vc
);
    int hops_cw;

    // Choose the target from the clockwise hop count and the dateline compare.
    always_comb begin
        hops_cw = (int'(dest) + N - NODE_ID) % N;
        if (hops_cw == 0)
            tgt = TGT_LOCAL;
        else if (hops_cw <= N / 2)
            tgt = TGT_CW;
        else
            tgt = TGT_CCW;
        vc = ((NODE_ID % D) > (int'(dest) % D)) ? 1'b0 : 1'b1;
    end
endmodule

// File: rtl/flit_queue.sv
// Small circular flit queue for one virtual channel of one output link.
// Assumes the caller never pushes when full nor pops when empty.
module flit_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/ring_out_arb.sv
// Output arbiter of one ring link: round-robin between the two virtual
// networks each cycle, then winner-takes-all between the two channels of the
// chosen network (a started packet holds its network's share until its tail).
// Assumes q_tail reflects the head entry of each non-empty queue.
module ring_out_arb
    import ring_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_Q-1:0]  q_avail,
    input  logic [NUM_Q-1:0]  q_tail,
    input  logic [NUM_Q-1:0]  link_rdy,
    output logic              go,
    output logic [QSEL_W-1:0] sel,
    output logic [NUM_Q-1:0]  pop
);
    logic                last_vn;
    logic [NUM_VN-1:0]   lock_vld, lock_vc;
    logic [NUM_VC-1:0]   elig [NUM_VN];
    logic [NUM_VN-1:0]   vn_ok, vc_pick;
    logic                vn_sel;

    // Eligibility per queue, then channel pick inside each network.
    always_comb begin
        for (int v = 0; v < NUM_VN; v++) begin
            for (int c = 0; c < NUM_VC; c++) begin
                elig[v][c] = q_avail[v*NUM_VC+c] && link_rdy[v*NUM_VC+c] &&
                             (!lock_vld[v] || (lock_vc[v] == 1'(c)));
            end
            vn_ok[v]   = |elig[v];
            vc_pick[v] = !elig[v][0];
        end
    end

    // Round-robin network choice and the one-hot pop.
    always_comb begin
        vn_sel = vn_ok[~last_vn] ? ~last_vn : last_vn;
        go     = |vn_ok;
        sel    = {vn_sel, vc_pick[vn_sel]};
        pop    = go ? (NUM_Q'(1) << sel) : '0;
    end

    // Fairness pointer and per-network channel lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_vn  <= 1'b0;
            lock_vld <= '0;
            lock_vc  <= '0;
        end else if (go) begin
            last_vn          <= vn_sel;
            lock_vld[vn_sel] <= !q_tail[sel];
            lock_vc[vn_sel]  <= vc_pick[vn_sel];
        end
    end
endmodule

// File: rtl/ring_dateline_router.sv
// Forwarding stage of one ring node: single input register, head-flit path
// computation held for the body flits, local eject, and per link four
// queues (virtual network x channel) drained by a ring_out_arb each.
// Assumes packets arrive unbroken with a constant virtual network.
module ring_dateline_router
    import ring_rtr_pkg::*;
#(
    parameter int N       = 8,
    parameter int D       = 4,
    parameter int NODE_ID = 2,
    parameter int DW      = 16,
    parameter int QDEPTH  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_head,
    input  logic                 in_tail,
    input  logic                 in_vnet,
    input  logic [$clog2(N)-1:0] in_dest,
    input  logic [DW-1:0]        in_data,
    output logic                 loc_valid,
    input  logic                 loc_ready,
    output logic                 loc_head,
    output logic                 loc_tail,
    output logic                 loc_vnet,
    output logic [$clog2(N)-1:0] loc_dest,
    output logic [DW-1:0]        loc_data,
    output logic                 cw_valid,
    output logic                 cw_head,
    output logic                 cw_tail,
    output logic                 cw_vnet,
    output logic                 cw_vc,
    output logic [$clog2(N)-1:0] cw_dest,
    output logic [DW-1:0]        cw_data,
    input  logic [3:0]           cw_rdy,
    output logic                 ccw_valid,
    output logic                 ccw_head,
    output logic                 ccw_tail,
    output logic                 ccw_vnet,
    output logic                 ccw_vc,
    output logic [$clog2(N)-1:0] ccw_dest,
    output logic [DW-1:0]        ccw_data,
    input  logic [3:0]           ccw_rdy
);
    localparam int IDW = $clog2(N);
    localparam int FW  = 3 + IDW + DW;

    typedef struct packed {
        logic           head;
        logic           tail;
        logic           vnet;
        logic [IDW-1:0] dest;
        logic [DW-1:0]  data;
    } flit_t;

    flit_t                     r_flit;
    logic                      r_vld;
    tgt_e                      rc_tgt, pth_tgt, cur_tgt;
    logic                      rc_vc, pth_vc, cur_vc;
    logic [QSEL_W-1:0]         cur_q;
    logic                      cur_dir, drain;
    logic [NUM_DIR*NUM_Q-1:0]  q_full;
    logic [NUM_Q-1:0]          link_rdy [NUM_DIR];
    logic [NUM_DIR-1:0]        dir_valid, dir_vc;
    flit_t                     dir_flit [NUM_DIR];

    assign link_rdy[0] = cw_rdy;
    assign link_rdy[1] = ccw_rdy;

    ring_route_calc #(.N(N), .D(D), .NODE_ID(NODE_ID), .IDW(IDW)) u_route (
        .dest (r_flit.dest),
        .tgt  (rc_tgt),
        .vc   (rc_vc)
    );

    // Head flits use the fresh route, body flits the held one; decide drain.
    always_comb begin
        cur_tgt = r_flit.head ? rc_tgt : pth_tgt;
        cur_vc  = r_flit.head ? rc_vc  : pth_vc;
        cur_q   = {r_flit.vnet, cur_vc};
        cur_dir = (cur_tgt == TGT_CCW);
        if (cur_tgt == TGT_LOCAL)
            drain = r_vld && loc_ready;
        else
            drain = r_vld && !q_full[{cur_dir, cur_q}];
    end

    assign in_ready = !r_vld || drain;

    // Single-stage input register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_vld  <= 1'b0;
            r_flit <= '0;
        end else if (in_ready) begin
            r_vld  <= in_valid;
            r_flit <= '{head: in_head, tail: in_tail, vnet: in_vnet,
                        dest: in_dest, data: in_data};
        end
    end

    // Hold the path opened by a head flit for the rest of its packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pth_tgt <= TGT_LOCAL;
            pth_vc  <= 1'b0;
        end else if (drain && r_flit.head) begin
            pth_tgt <= rc_tgt;
            pth_vc  <= rc_vc;
        end
    end

    assign loc_valid = r_vld && (cur_tgt == TGT_LOCAL);
    assign loc_head  = r_flit.head;
    assign loc_tail  = r_flit.tail;
    assign loc_vnet  = r_flit.vnet;
    assign loc_dest  = r_flit.dest;
    assign loc_data  = r_flit.data;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_link
        localparam tgt_e MY_TGT = (d == 0) ? TGT_CW : TGT_CCW;
        flit_t             q_dout [NUM_Q];
        logic [NUM_Q-1:0]  q_empty, q_push, q_pop, q_tail;
        logic              go;
        logic [QSEL_W-1:0] sel;

        for (genvar q = 0; q < NUM_Q; q++) begin : g_q
            assign q_push[q] = drain && (cur_tgt == MY_TGT) && (cur_q == QSEL_W'(q));
            assign q_tail[q] = q_dout[q].tail;
            flit_queue #(.W(FW), .DEPTH(QDEPTH)) u_queue (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (q_push[q]),
                .din   (r_flit),
                .pop   (q_pop[q]),
                .dout  (q_dout[q]),
                .empty (q_empty[q]),
                .full  (q_full[d*NUM_Q+q])
            );
        end

        ring_out_arb u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .q_avail  (~q_empty),
            .q_tail   (q_tail),
            .link_rdy (link_rdy[d]),
            .go       (go),
            .sel      (sel),
            .pop      (q_pop)
        );

        assign dir_valid[d] = go;
        assign dir_vc[d]    = sel[0];
        assign dir_flit[d]  = q_dout[sel];
    end

    assign cw_valid  = dir_valid[0];
    assign cw_head   = dir_flit[0].head;
    assign cw_tail   = dir_flit[0].tail;
    assign cw_vnet   = dir_flit[0].vnet;
    assign cw_vc     = dir_vc[0];
    assign cw_dest   = dir_flit[0].dest;
    assign cw_data   = dir_flit[0].data;
    assign ccw_valid = dir_valid[1];
    assign ccw_head  = dir_flit[1].head;
    assign ccw_tail  = dir_flit[1].tail;
    assign ccw_vnet  = dir_flit[1].vnet;
    assign ccw_vc    = dir_vc[1];
    assign ccw_dest  = dir_flit[1].dest;
    assign ccw_data  = dir_flit[1].data;
endmodule

// File: rtl/ring_router_checks.sv
// Port-level properties of ring_dateline_router, attached by bind below.
// Keeps its own record of which channel holds each link per virtual network.
module ring_router_checks #(
    parameter int N       = 8,
    parameter int D       = 4,
    parameter int NODE_ID = 2,
    parameter int IDW     = $clog2(N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_ready,
    input logic           loc_valid,
    input logic [IDW-1:0] loc_dest,
    input logic           cw_valid,
    input logic           cw_head,
    input logic           cw_tail,
    input logic           cw_vnet,
    input logic           cw_vc,
    input logic [IDW-1:0] cw_dest,
    input logic [3:0]     cw_rdy,
    input logic           ccw_valid,
    input logic           ccw_head,
    input logic           ccw_tail,
    input logic           ccw_vnet,
    input logic           ccw_vc,
    input logic [IDW-1:0] ccw_dest,
    input logic [3:0]     ccw_rdy
);
    logic [1:0] cw_open, cw_ovc, ccw_open, ccw_ovc;

    function automatic int hops(input logic [IDW-1:0] dst);
        return (int'(dst) + N - NODE_ID) % N;
    endfunction

    function automatic logic line_vc(input logic [IDW-1:0] dst);
        return ((NODE_ID % D) > (int'(dst) % D)) ? 1'b0 : 1'b1;
    endfunction

    // Track the open packet per virtual network on each link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw_open  <= '0;
            cw_ovc   <= '0;
            ccw_open <= '0;
            ccw_ovc  <= '0;
        end else begin
            if (cw_valid) begin
                cw_open[cw_vnet] <= !cw_tail;
                cw_ovc[cw_vnet]  <= cw_vc;
            end
            if (ccw_valid) begin
                ccw_open[ccw_vnet] <= !ccw_tail;
                ccw_ovc[ccw_vnet]  <= ccw_vc;
            end
        end
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !loc_valid && !cw_valid && !ccw_valid));

    assert_local_only_own_R2: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid |-> (int'(loc_dest) == NODE_ID));

    assert_cw_shorter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> (hops(cw_dest) != 0 && hops(cw_dest) <= N / 2));

    assert_ccw_shorter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ccw_valid |-> (hops(ccw_dest) > N / 2));

    assert_cw_dateline_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> (cw_vc == line_vc(cw_dest)));

    assert_ccw_dateline_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ccw_valid |-> (ccw_vc == line_vc(ccw_dest)));

    assert_cw_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> cw_rdy[{cw_vnet, cw_vc}]);

    assert_ccw_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ccw_valid |-> ccw_rdy[{ccw_vnet, ccw_vc}]);

    assert_cw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_open[cw_vnet]) |-> (cw_vc == cw_ovc[cw_vnet] && !cw_head));

    assert_ccw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ccw_valid && ccw_open[ccw_vnet]) |-> (ccw_vc == ccw_ovc[ccw_vnet] && !ccw_head));
endmodule

bind ring_dateline_router ring_router_checks #(.N(N), .D(D), .NODE_ID(NODE_ID)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .loc_valid (loc_valid),
    .loc_dest  (loc_dest),
    .cw_valid  (cw_valid),
    .cw_head   (cw_head),
    .cw_tail   (cw_tail),
    .cw_vnet   (cw_vnet),
    .cw_vc     (cw_vc),
    .cw_dest   (cw_dest),
    .cw_rdy    (cw_rdy),
    .ccw_valid (ccw_valid),
    .ccw_head  (ccw_head),
    .ccw_tail  (ccw_tail),
    .ccw_vnet  (ccw_vnet),
    .ccw_vc    (ccw_vc),
    .ccw_dest  (ccw_dest),
    .ccw_rdy   (ccw_rdy)
);

// File: tb/ring_dateline_router_bench.sv
module ring_dateline_router_bench;
    localparam int N = 8, D = 4, NODE_ID = 2, DW = 16;
    localparam int IDW = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_head = 1'b0, in_tail = 1'b0, in_vnet = 1'b0;
    logic [IDW-1:0] in_dest = '0;
    logic [DW-1:0]  in_data = '0;
    logic in_ready, loc_valid, loc_ready = 1'b1, loc_head, loc_tail, loc_vnet;
    logic [IDW-1:0] loc_dest, cw_dest, ccw_dest;
    logic [DW-1:0]  loc_data, cw_data, ccw_data;
    logic cw_valid, cw_head, cw_tail, cw_vnet, cw_vc;
    logic ccw_valid, ccw_head, ccw_tail, ccw_vnet, ccw_vc;
    logic [3:0] cw_rdy = 4'h0, ccw_rdy = 4'h0;

    always #4 clk = ~clk;

    ring_dateline_router #(.N(N), .D(D), .NODE_ID(NODE_ID), .DW(DW)) u_ring_dateline_router (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_head(in_head), .in_tail(in_tail),
        .in_vnet(in_vnet), .in_dest(in_dest), .in_data(in_data),
        .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_head(loc_head), .loc_tail(loc_tail),
        .loc_vnet(loc_vnet), .loc_dest(loc_dest), .loc_data(loc_data),
        .cw_valid(cw_valid), .cw_head(cw_head), .cw_tail(cw_tail), .cw_vnet(cw_vnet),
        .cw_vc(cw_vc), .cw_dest(cw_dest), .cw_data(cw_data), .cw_rdy(cw_rdy),
        .ccw_valid(ccw_valid), .ccw_head(ccw_head), .ccw_tail(ccw_tail), .ccw_vnet(ccw_vnet),
        .ccw_vc(ccw_vc), .ccw_dest(ccw_dest), .ccw_data(ccw_data), .ccw_rdy(ccw_rdy)
    );

    typedef struct packed {
        logic           head;
        logic           tail;
        logic [IDW-1:0] dest;
        logic [DW-1:0]  data;
    } ent_t;

    ent_t sb [9][$];
    int n_chk = 0, n_fail = 0, acc_cnt = 0;
    logic [DW-1:0] data_ctr = '0;
    bit mon_on = 0, rec_on = 0, rnd_on = 0, sent_done = 0;
    bit open_pk [2][2];
    bit open_vc [2][2];
    bit seq_vn [$];
    bit seq_vc [$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Queue index expected from the requirements: 8 = local, else dir*4+vnet*2+vc.
    function automatic int exp_key(input bit vn, input int dest);
        int h, dir, vc;
        h = (dest + N - NODE_ID) % N;
        if (h == 0) return 8;
        dir = (h <= N / 2) ? 0 : 1;
        vc  = ((NODE_ID % D) > (dest % D)) ? 0 : 1;
        return dir * 4 + int'(vn) * 2 + vc;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_pkt(input bit vn, input int dest, input int len);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_head  = (i == 0);
            in_tail  = (i == len - 1);
            in_vnet  = vn;
            in_dest  = IDW'(dest);
            in_data  = data_ctr;
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            sb[exp_key(vn, dest)].push_back('{in_head, in_tail, in_dest, in_data});
            acc_cnt++;
            data_ctr++;
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic mon_link(input int d, input logic v, input logic h, input logic t,
                            input logic vn, input logic vc, input logic [IDW-1:0] dst,
                            input logic [DW-1:0] dat, input logic [3:0] rdy);
        int   key;
        ent_t e, got;
        if (!v) return;
        key = d * 4 + int'(vn) * 2 + int'(vc);
        check(rdy[{vn, vc}], "R6", "flit sent without ready bit", 0, 1);
        got = '{h, t, dst, dat};
        if (sb[key].size() == 0) begin
            check(0, "R3/R4", "flit on unexpected link or channel", key, -1);
        end else begin
            e = sb[key].pop_front();
            check(got == e, "R5", "flit contents/order", longint'(got), longint'(e));
        end
        if (open_pk[d][vn])
            check(vc == open_vc[d][vn] && !h, "R9", "channel switch mid-packet", vc, open_vc[d][vn]);
        open_pk[d][vn] = !t;
        open_vc[d][vn] = vc;
        if (rec_on && d == 0) begin
            seq_vn.push_back(vn);
            seq_vc.push_back(vc);
        end
    endtask

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            mon_link(0, cw_valid, cw_head, cw_tail, cw_vnet, cw_vc, cw_dest, cw_data, cw_rdy);
            mon_link(1, ccw_valid, ccw_head, ccw_tail, ccw_vnet, ccw_vc, ccw_dest, ccw_data, ccw_rdy);
            if (loc_valid && loc_ready) begin
                ent_t e, got;
                got = '{loc_head, loc_tail, loc_dest, loc_data};
                if (sb[8].size() == 0) begin
                    check(0, "R2", "unexpected local flit", longint'(got), -1);
                end else begin
                    e = sb[8].pop_front();
                    check(got == e, "R2", "local flit contents", longint'(got), longint'(e));
                end
            end
        end
    end

    // Random next-hop readiness during the random phase.
    always @(posedge clk) begin
        if (rnd_on) begin
            #2;
            if (rnd_on) begin
                cw_rdy    = 4'($urandom);
                ccw_rdy   = 4'($urandom);
                loc_ready = 1'($urandom);
            end
        end
    end

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R10", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4321);
        tick(4);
        rst_n = 1'b1;
        #0;
        // R1: state right after reset release
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(cw_valid == 1'b0, "R1", "cw_valid after reset", cw_valid, 0);
        check(ccw_valid == 1'b0, "R1", "ccw_valid after reset", ccw_valid, 0);
        check(loc_valid == 1'b0, "R1", "loc_valid after reset", loc_valid, 0);
        mon_on = 1;

        // R2: packet for this node ejects locally
        send_pkt(1'b0, NODE_ID, 3);
        tick(4);
        check(sb[8].size() == 0, "R2", "local packet drained", sb[8].size(), 0);

        // R7: queue depth with link stalled
        acc_cnt = 0;
        sent_done = 0;
        fork
            begin
                send_pkt(1'b1, 3, 5);
                sent_done = 1;
            end
        join_none
        tick(12);
        check(acc_cnt == 4, "R7", "flits accepted while stalled", acc_cnt, 4);
        check(in_ready == 1'b0, "R7", "in_ready while full", in_ready, 0);
        check(cw_valid == 1'b0, "R6", "no send without ready", cw_valid, 0);
        cw_rdy = 4'hF;
        wait (sent_done);
        tick(8);
        check(sb[exp_key(1'b1, 3)].size() == 0, "R7", "stalled packet drained",
              sb[exp_key(1'b1, 3)].size(), 0);

        // R8: alternation between virtual networks
        cw_rdy = 4'h0;
        send_pkt(1'b0, 4, 3);
        send_pkt(1'b1, 4, 3);
        tick(2);
        seq_vn.delete();
        seq_vc.delete();
        rec_on = 1;
        cw_rdy = 4'hF;
        tick(10);
        rec_on = 0;
        check(seq_vn.size() == 6, "R8", "flits seen", seq_vn.size(), 6);
        for (int i = 1; i < seq_vn.size(); i++)
            check(seq_vn[i] != seq_vn[i-1], "R8", "network alternation", seq_vn[i], !seq_vn[i-1]);

        // R9: winner keeps link; channel 0 wins when unheld
        cw_rdy = 4'h0;
        send_pkt(1'b0, 3, 3);
        send_pkt(1'b0, 4, 3);
        tick(2);
        seq_vn.delete();
        seq_vc.delete();
        rec_on = 1;
        cw_rdy = 4'hF;
        tick(10);
        rec_on = 0;
        check(seq_vc.size() == 6, "R9", "flits seen", seq_vc.size(), 6);
        if (seq_vc.size() == 6)
            for (int i = 0; i < 6; i++)
                check(seq_vc[i] == (i >= 3), "R9", "channel order", seq_vc[i], i >= 3);

        // R3 R4: every destination once, both links open
        ccw_rdy = 4'hF;
        for (int dst = 0; dst < N; dst++)
            send_pkt(1'(dst), dst, 2);
        tick(10);
        for (int k = 0; k < 9; k++)
            check(sb[k].size() == 0, "R3", "directed sweep drained", sb[k].size(), 0);

        // Random phase
        rnd_on = 1;
        for (int p = 0; p < 80; p++) begin
            tick($urandom % 3);
            send_pkt(1'($urandom), $urandom % N, 1 + $urandom % 4);
        end
        rnd_on = 0;
        tick(1);
        cw_rdy = 4'hF;
        ccw_rdy = 4'hF;
        loc_ready = 1'b1;
        tick(40);
        for (int k = 0; k < 9; k++)
            check(sb[k].size() == 0, "R10", "every flit delivered", sb[k].size(), 0);
        report();
        $finish;
    end
endmodule